// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is a synthesizable two-wire (I2C) slave that fronts an on-chip byte array of 4096 locations. The bus lines arrive as plain inputs and are oversampled by the system clock. The block detects START and STOP conditions, decodes a 7-bit device address made of a fixed `1010` prefix and three strap inputs, and acknowledges bytes by pulling SDA low through an open-drain enable. Writes collect in a 32-byte page buffer and reach the array only after the STOP. Reads return bytes at an internal pointer that advances as the master acknowledges them.

A write command is the device byte with the direction bit at 0, two word-address bytes (upper byte first) and up to any number of data bytes. A random read is a write command with no data bytes, then a repeated START and the device byte with the direction bit at 1. A current-address read is the read device byte alone. After a committed write the block runs a timed internal cycle of `WR_CYCLES` clocks. During that cycle it does not acknowledge its device address, so a master can poll for completion. A write-protect input lets every transfer run normally on the bus but discards the buffered bytes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Out of reset the SDA pull-down enable `sda_oe_o` is 0 (line released) and the slave waits for a START.
- R2: Only the device byte whose bits 7..1 equal `1010` followed by `strap_i[2:0]` is acknowledged. Bit 0 is the direction: 1 read, 0 write. On any other device byte the slave does not acknowledge that byte or any byte after it until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Clocked bytes sent before any START get no acknowledge.
- R4: `sda_oe_o` (1 = pull SDA low) changes only while the sampled SCL is low. The slave never drives SDA high.
- R5: A write command acknowledges the device byte, both address bytes and every data byte. Only the low 4 bits of the first address byte are used. Data bytes are stored at the addressed location once the STOP is seen.
- R6: The low 5 address bits advance per data byte and wrap within the same 32-byte page. When more than 32 bytes are sent, the later byte for a location replaces the earlier one.
- R7: After a STOP ends a write with at least one data byte, the slave does not acknowledge its device address for `WR_CYCLES` clocks. After that it acknowledges again.
- R8: With `wp_i` high at the STOP, every byte is still acknowledged. The array is not changed and no busy interval starts, so the device address is acknowledged at once.
- R9: A random read (address write, repeated START, read device byte) returns the byte stored at the sent address.
- R10: During a read the pointer advances after each byte the master acknowledges, across pages, wrapping from 4095 to 0.
- R11: A current-address read starts at the internal pointer. The pointer is left one past the last written byte (within its page) by a write, and at the not-acknowledged byte by a read.
- R12: After the master does not acknowledge a read byte, the slave releases SDA and stays quiet until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Pin-strapped low device address bits |
| wp_i | input | 1 | Write protect: high discards write commands |
| sda_oe_o | output | 1 | SDA pull-down enable, 1 pulls the line low |

## Verification
The assertions check on every cycle that the pull-down enable changes only while SCL is low, that no device acknowledge is given during a busy interval, and that no busy interval starts while write protect is high. They also check that the page buffer and the commit request are never touched during an internal write, and that the silent state never drives the line. Only the bench scenarios show the stored data itself: page wrap and overrun, upper address bits being ignored, pointer movement across writes, sequential reads and the 4095-to-0 wrap. The bench compares every returned byte against its own memory model, under both directed corner cases and seeded random page writes.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eep_st_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_W-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_W-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_W-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_W-1];
      sda_q  <= sda_sh[SYNC_W-1];
    end
  end

  assign scl_o      = scl_sh[SYNC_W-1];
  assign sda_o      = sda_sh[SYNC_W-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL held high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_s_i,
  input  logic                     sda_s_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic [2:0]               strap_i,
  input  logic                     wp_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     sda_oe_o,
  output logic                     buf_clr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_idx_o,
  output logic [7:0]               buf_data_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] commit_page_o
);
  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  eep_st_e            st_q;
  logic [3:0]         cnt_q;
  logic               in_ack_q;
  logic [7:0]         shift_q;
  logic               sda_oe_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [HI_W-1:0]    hi_q;
  logic               mack_q;
  logic               wrote_q;
  logic               buf_clr_q, buf_we_q, commit_q;
  logic [PAGE_W-1:0]  buf_idx_q;
  logic [7:0]         buf_data_q;
  logic [PG_W-1:0]    commit_page_q;
  logic               look_next;

  // during a read ack slot the array is addressed one ahead
  assign look_next = (st_q == ST_RDAT) && in_ack_q;
  assign rd_addr_o = ptr_q + {{(ADDR_W-1){1'b0}}, look_next};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      in_ack_q      <= 1'b0;
      shift_q       <= '0;
      sda_oe_q      <= 1'b0;
      ptr_q         <= '0;
      hi_q          <= '0;
      mack_q        <= 1'b0;
      wrote_q       <= 1'b0;
      buf_clr_q     <= 1'b0;
      buf_we_q      <= 1'b0;
      commit_q      <= 1'b0;
      buf_idx_q     <= '0;
      buf_data_q    <= '0;
      commit_page_q <= '0;
    end else begin
      buf_clr_q <= 1'b0;
      buf_we_q  <= 1'b0;
      commit_q  <= 1'b0;
      if (start_i) begin
        st_q     <= ST_DEV;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (stop_i) begin
        commit_q      <= (st_q == ST_WDAT) && wrote_q && !wp_i;
        commit_page_q <= ptr_q[ADDR_W-1:PAGE_W];
        st_q          <= ST_IDLE;
        in_ack_q      <= 1'b0;
        sda_oe_q      <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i) begin
          if (!in_ack_q && cnt_q < 4'd8) begin
            cnt_q <= cnt_q + 4'd1;
            if (st_q != ST_RDAT) shift_q <= {shift_q[6:0], sda_s_i};
          end else if (in_ack_q && st_q == ST_RDAT) begin
            mack_q <= ~sda_s_i;
          end
        end else if (scl_fall_i) begin
          if (!in_ack_q && cnt_q == 4'd8) begin
            in_ack_q <= 1'b1;
            unique case (st_q)
              ST_DEV: begin
                if (shift_q[7:1] == {DEV_PREFIX, strap_i} && !busy_i) sda_oe_q <= 1'b1;
                else st_q <= ST_IDLE;
              end
              ST_AHI: begin
                sda_oe_q <= 1'b1;
                hi_q     <= shift_q[HI_W-1:0];
              end
              ST_ALO: begin
                sda_oe_q  <= 1'b1;
                ptr_q     <= {hi_q, shift_q};
                buf_clr_q <= 1'b1;
                wrote_q   <= 1'b0;
              end
              ST_WDAT: begin
                sda_oe_q   <= 1'b1;
                buf_we_q   <= 1'b1;
                buf_idx_q  <= ptr_q[PAGE_W-1:0];
                buf_data_q <= shift_q;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
                wrote_q    <= 1'b1;
              end
              ST_RDAT: sda_oe_q <= 1'b0;
              default: ;
            endcase
          end else if (in_ack_q) begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
            unique case (st_q)
              ST_DEV: begin
                if (shift_q[0]) begin
                  st_q     <= ST_RDAT;
                  shift_q  <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[7];
                end else begin
                  st_q <= ST_AHI;
                end
              end
              ST_AHI: st_q <= ST_ALO;
              ST_ALO: st_q <= ST_WDAT;
              ST_RDAT: begin
                if (mack_q) begin
                  ptr_q    <= ptr_q + 1'b1;
                  shift_q  <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[7];
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              default: ;
            endcase
          end else if (st_q == ST_RDAT && cnt_q != 4'd0) begin
            shift_q  <= {shift_q[6:0], 1'b0};
            sda_oe_q <= ~shift_q[6];
          end
        end
      end
    end
  end

  assign sda_oe_o      = sda_oe_q;
  assign buf_clr_o     = buf_clr_q;
  assign buf_we_o      = buf_we_q;
  assign buf_idx_o     = buf_idx_q;
  assign buf_data_o    = buf_data_q;
  assign commit_o      = commit_q;
  assign commit_page_o = commit_page_q;

  // R4
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> !scl_s_i);

  // R7
  busy_dev_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_q) && st_q == ST_DEV) |-> !$past(busy_i));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !sda_oe_q);

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 10000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     buf_clr_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int TMR_W  = $clog2(WR_CYCLES + 1);

  logic [PAGE_N-1:0] vld_w;
  logic [7:0]        dat_w [PAGE_N];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_ent
    logic       vld;
    logic [7:0] dat;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld <= 1'b0;
        dat <= '0;
      end else if (buf_clr_i) begin
        vld <= 1'b0;
      end else if (buf_we_i && buf_idx_i == PAGE_W'(g)) begin
        vld <= 1'b1;
        dat <= buf_data_i;
      end
    end
    assign vld_w[g] = vld;
    assign dat_w[g] = dat;
  end

  logic [TMR_W-1:0]  tmr_q;
  logic [PAGE_W:0]   idx_q;
  logic [PG_W-1:0]   page_q;
  logic              idx_run, mem_we;
  logic [ADDR_W-1:0] waddr;

  assign idx_run = !idx_q[PAGE_W];
  assign mem_we  = idx_run && vld_w[idx_q[PAGE_W-1:0]];
  assign waddr   = {page_q, idx_q[PAGE_W-1:0]};
  assign busy_o  = (tmr_q != '0) || idx_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      idx_q  <= (PAGE_W+1)'(PAGE_N);
      page_q <= '0;
    end else if (commit_i) begin
      tmr_q  <= TMR_W'(WR_CYCLES);
      idx_q  <= '0;
      page_q <= commit_page_i;
    end else begin
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      if (idx_run) idx_q <= idx_q + 1'b1;
    end
  end

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[waddr] <= dat_w[idx_q[PAGE_W-1:0]];
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R7
  buf_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_i || buf_clr_i) |-> !busy_o);

  // R7
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_o);

  // R5
  write_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> $past(busy_o) || $past(commit_i));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 10000,
  parameter int SYNC_W    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy;
  logic [7:0] rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic buf_clr, buf_we, commit;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0] buf_data;
  logic [PG_W-1:0] commit_page;

  eep_bus_sync #(.SYNC_W(SYNC_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  eep_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .scl_s_i       (scl_s),
    .sda_s_i       (sda_s),
    .scl_rise_i    (scl_rise),
    .scl_fall_i    (scl_fall),
    .start_i       (start_ev),
    .stop_i        (stop_ev),
    .strap_i       (strap_i),
    .wp_i          (wp_i),
    .busy_i        (busy),
    .rd_data_i     (rd_data),
    .rd_addr_o     (rd_addr),
    .sda_oe_o      (sda_oe_o),
    .buf_clr_o     (buf_clr),
    .buf_we_o      (buf_we),
    .buf_idx_o     (buf_idx),
    .buf_data_o    (buf_data),
    .commit_o      (commit),
    .commit_page_o (commit_page)
  );

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .buf_clr_i     (buf_clr),
    .buf_we_i      (buf_we),
    .buf_idx_i     (buf_idx),
    .buf_data_i    (buf_data),
    .commit_i      (commit),
    .commit_page_i (commit_page),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data),
    .busy_o        (busy)
  );

  // R8
  wp_no_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp_i, 2));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
  localparam int H = 8;
  localparam int WRC = 400;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (STRAP),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int r4_viol = 0;
  logic [7:0]  ref_mem [4096];
  bit          known [4096];
  logic [11:0] ref_ptr = '0;
  logic [7:0]  wbuf [64];

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R4: enable may only move while the master holds SCL low
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r4_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] dev(input bit rd, input logic [2:0] st);
    return {4'b1010, st, rd};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    nack = sda_line;
    tick(H/2);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H/2);
      d[i] = sda_line;
      tick(H/2);
      scl_m = 1'b0;
    end
    sda_m = ~ack; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H);
    sda_m = 1'b1;
  endtask

  task automatic wr_page(input logic [11:0] a, input int n, input logic [3:0] junk);
    bit nk;
    string rq;
    rq = wp ? "R8" : "R5";
    i2c_start();
    send_byte(dev(1'b0, STRAP), nk); check(!nk, rq, "write dev ack", nk, 0);
    send_byte({junk, a[11:8]}, nk);  check(!nk, rq, "addr hi ack", nk, 0);
    send_byte(a[7:0], nk);           check(!nk, rq, "addr lo ack", nk, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk);
      check(!nk, rq, "data ack", nk, 0);
    end
    i2c_stop();
    for (int i = 0; i < n; i++) begin
      logic [4:0] off;
      off = a[4:0] + 5'(i);
      if (!wp) begin
        ref_mem[{a[11:5], off}] = wbuf[i];
        known[{a[11:5], off}] = 1'b1;
      end
    end
    ref_ptr = {a[11:5], a[4:0] + 5'(n)};
  endtask

  task automatic poll_once(output bit nk);
    i2c_start();
    send_byte(dev(1'b0, STRAP), nk);
    i2c_stop();
  endtask

  task automatic wait_ready();
    bit nk = 1'b1;
    int polls = 0;
    while (nk && polls < 30) begin
      poll_once(nk);
      polls++;
    end
    check(!nk, "R7", "acknowledged again after write cycle", polls, 0);
  endtask

  task automatic read_body(input logic [11:0] a, input int n, input string tag);
    logic [7:0] d;
    logic [11:0] ad;
    for (int i = 0; i < n; i++) begin
      ad = a + 12'(i);
      recv_byte(i != n - 1, d);
      if (known[ad]) check(d === ref_mem[ad], tag, "read data", d, ref_mem[ad]);
    end
    check(sda_oe === 1'b0, "R12", "line released after nack", sda_oe, 0);
    i2c_stop();
    ref_ptr = a + 12'(n - 1);
  endtask

  task automatic read_seq(input logic [11:0] a, input int n, input string tag);
    bit nk;
    i2c_start();
    send_byte(dev(1'b0, STRAP), nk); check(!nk, "R9", "dummy write dev ack", nk, 0);
    send_byte({4'h0, a[11:8]}, nk);  check(!nk, "R9", "addr hi ack", nk, 0);
    send_byte(a[7:0], nk);           check(!nk, "R9", "addr lo ack", nk, 0);
    i2c_rstart();
    send_byte(dev(1'b1, STRAP), nk); check(!nk, "R9", "read dev ack", nk, 0);
    read_body(a, n, tag);
  endtask

  task automatic read_cur(input int n, input string tag);
    bit nk;
    i2c_start();
    send_byte(dev(1'b1, STRAP), nk); check(!nk, "R11", "current read dev ack", nk, 0);
    read_body(ref_ptr, n, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit nk;
    logic [7:0] old;
    void'($urandom(32'd1234));
    tick(10);
    check(sda_oe === 1'b0, "R1", "reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(4);
    check(sda_oe === 1'b0, "R1", "idle after reset", sda_oe, 0);

    // R3: byte clocked without START
    scl_m = 1'b0; tick(H);
    send_byte(dev(1'b0, STRAP), nk);
    check(nk, "R3", "no ack without start", nk, 1);
    i2c_stop();

    // R2: wrong strap, then following byte ignored
    i2c_start();
    send_byte(dev(1'b0, 3'b010), nk); check(nk, "R2", "wrong strap nack", nk, 1);
    send_byte(8'h00, nk);             check(nk, "R2", "later byte ignored", nk, 1);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, STRAP, 1'b0}, nk); check(nk, "R2", "wrong prefix nack", nk, 1);
    i2c_stop();

    // R5 byte write with junk upper nibble, R7 busy polling
    wbuf[0] = 8'h3c;
    wr_page(12'h0a5, 1, 4'hf);
    poll_once(nk);
    check(nk, "R7", "nack while busy", nk, 1);
    wait_ready();
    read_seq(12'h0a5, 1, "R5");

    // R6 page wrap from offset 28
    for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
    wr_page(12'h07c, 8, 4'h0);
    wait_ready();
    read_seq(12'h07c, 4, "R6");
    read_seq(12'h060, 4, "R6");

    // R6 overrun: 35 bytes to a page, last writes win
    for (int i = 0; i < 35; i++) wbuf[i] = 8'($urandom);
    wr_page(12'h200, 35, 4'h5);
    wait_ready();
    read_seq(12'h200, 32, "R6");

    // R8 write protect
    wp = 1'b1;
    old = ref_mem[12'h07c];
    wbuf[0] = ~old;
    wr_page(12'h07c, 1, 4'h0);
    poll_once(nk);
    check(!nk, "R8", "no busy under protect", nk, 0);
    wp = 1'b0;
    read_seq(12'h07c, 1, "R8");

    // R10 wrap 4095 -> 0
    wbuf[0] = 8'ha1; wbuf[1] = 8'hb2;
    wr_page(12'hffe, 2, 4'h0);
    wait_ready();
    wbuf[0] = 8'hc3; wbuf[1] = 8'hd4;
    wr_page(12'h000, 2, 4'h0);
    wait_ready();
    read_seq(12'hffe, 4, "R10");

    // R11 pointer after nack-ended read, then after a write
    read_cur(1, "R11");
    wbuf[0] = 8'h5a;
    wr_page(12'h200, 1, 4'h0);
    wait_ready();
    read_cur(2, "R11");

    // random page writes
    for (int it = 0; it < 6; it++) begin
      logic [11:0] a;
      int n, first;
      a = 12'($urandom);
      n = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_page(a, n, 4'($urandom));
      wait_ready();
      first = 32 - int'(a[4:0]);
      if (first >= n) begin
        read_seq(a, n, "R6");
      end else begin
        read_seq(a, first, "R6");
        read_seq({a[11:5], 5'd0}, n - first, "R6");
      end
    end

    check(r4_viol == 0, "R4", "enable moved while SCL high", r4_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule